// File: doc/BRIEF.md
# Two-Core Mailbox with Hardware Lock

This block lets two processor cores signal each other through a small register window. Each core owns one mailbox word. The other core writes into that word to raise an event. The word can be changed in three ways. A plain write replaces it. A set alias ORs bits in. A clear alias removes bits. Because of the two aliases, neither core has to read, modify and write the word back. Each mailbox drives an interrupt line to its owner, and the line stays high while any bit of the word is set.

A single lock bit lets the two cores share a resource. A core reads the lock register to try to take it. The read returns 1 when the lock was free, and the same access marks the lock taken. If the lock is already held, the read returns 0. The holder writes 1 to the register to free it.

The bus side is a simple single-cycle port. Read data is combinational in the cycle the read enable is high, and every state change happens at the clock edge that ends the access.

Top module: `ipc_mbox_top`

## Requirements
- R1: After reset both mailbox words read as zero and both interrupt lines are low. The lock is free, so the first read of the lock register returns 1.
- R2: Mailbox n has its data register at byte address 16*n (0x00 for mailbox 0, 0x10 for mailbox 1). A write there replaces the whole word from the next clock edge. A read returns the current word in the same cycle.
- R3: A write to the set alias at 16*n+4 ORs the write data into word n. Writing zero leaves the word unchanged.
- R4: A write to the clear alias at 16*n+8 clears every bit of word n whose write-data bit is 1. Writing zero leaves the word unchanged.
- R5: Bit n of `irq_o` is registered. It equals the OR of word n's bits and changes at the same clock edge as the word.
- R6: A read of the lock register at 0xF8 while the lock is free returns 1 in bit 0, with all other bits zero, and marks the lock taken.
- R7: A read of the lock register while the lock is taken returns 0 and leaves it taken.
- R8: A write to 0xF8 with bit 0 set frees the lock. A write with bit 0 clear leaves the lock unchanged.
- R9: Reads and writes to any address other than 0xF8 leave the lock state unchanged.
- R10: The following locations read as zero and ignore writes: the set and clear aliases, the word at 16*n+12, slots 2 to 14, addresses 0xF0 and 0xF4, and any address whose two low bits are not zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wen | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read enable |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_ren |
| irq_o | output | 2 | Per-mailbox interrupt, bit n for mailbox n |

## Verification
The bench sweeps every word address of the window with writes and reads, and predicts each result from an arithmetic model.

- **Decoder truncation:** a decoder that kept too few slot bits would let the reserved slots alias onto the two mailboxes. The sweep would then see a word change after a write that should have been ignored.
- **Lock sequences:** the lock is driven through back-to-back reads, a write of zero, and unrelated reads in between. A design that grants twice, frees on any write, or changes state on a foreign read returns the wrong grant bit.
- **Alias corner cases:** set and clear writes of zero and of all ones are applied. A design that treats an alias as a plain overwrite corrupts the word, and one that reads the aliases back as the word returns a non-zero value.
- **Interrupt timing:** the interrupt lines are compared after every access. A line that lags the word by a cycle is caught.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  // register select within a 16-byte mailbox slot (address bits 3:2)
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_SET  = 2'd1,
    SEL_CLR  = 2'd2,
    SEL_RSVD = 2'd3
  } slot_sel_e;

  localparam int unsigned SLOT_LSB = 4;
  localparam int unsigned LOCK_OFS = 32'hF8;
endpackage

// File: rtl/ipc_mbox_decode.sv
module ipc_mbox_decode
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_BOX = 2
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wen,
  input  logic               ren,
  output logic [NUM_BOX-1:0] wr_data,
  output logic [NUM_BOX-1:0] wr_set,
  output logic [NUM_BOX-1:0] wr_clr,
  output logic [NUM_BOX-1:0] rd_data,
  output logic               lock_rd,
  output logic               lock_wr
);
  localparam int unsigned SLOT_W = ADDR_W - SLOT_LSB;

  logic              aligned;
  logic [1:0]        reg_sel;
  logic [SLOT_W-1:0] slot;
  logic              lock_hit;

  assign aligned  = (addr[1:0] == 2'b00);
  assign reg_sel  = addr[3:2];
  assign slot     = addr[ADDR_W-1:SLOT_LSB];
  assign lock_hit = (addr == ADDR_W'(LOCK_OFS));
  assign lock_rd  = ren & lock_hit;
  assign lock_wr  = wen & lock_hit;

  for (genvar i = 0; i < NUM_BOX; i++) begin : g_box
    logic hit;
    assign hit        = aligned && (slot == SLOT_W'(i));
    assign wr_data[i] = wen & hit & (reg_sel == SEL_DATA);
    assign wr_set[i]  = wen & hit & (reg_sel == SEL_SET);
    assign wr_clr[i]  = wen & hit & (reg_sel == SEL_CLR);
    assign rd_data[i] = ren & hit & (reg_sel == SEL_DATA);
  end
endmodule

// File: rtl/ipc_mbox_word.sv
module ipc_mbox_word #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data,
  input  logic              wr_set,
  input  logic              wr_clr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] word_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] word_q, word_d;
  logic              irq_q, irq_d;
  logic              upd_en;

  assign upd_en = wr_data | wr_set | wr_clr;

  always_comb begin
    word_d = word_q;
    if (wr_data)     word_d = wdata;
    else if (wr_set) word_d = word_q | wdata;
    else if (wr_clr) word_d = word_q & ~wdata;
    irq_d = |word_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      irq_q  <= 1'b0;
    end else if (upd_en) begin
      word_q <= word_d;
      irq_q  <= irq_d;
    end
  end

  assign word_o = word_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/ipc_mbox_lock.sv
module ipc_mbox_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic acq_rd,
  input  logic rel_wr,
  output logic free_o
);
  logic free_q, free_d, free_en;

  assign free_en = acq_rd | rel_wr;

  always_comb begin
    free_d = free_q;
    if (rel_wr)      free_d = 1'b1;
    else if (acq_rd) free_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       free_q <= 1'b1;
    else if (free_en) free_q <= free_d;
  end

  assign free_o = free_q;
endmodule

// File: rtl/ipc_mbox_top.sv
module ipc_mbox_top #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_BOX = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wen,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_ren,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_BOX-1:0] irq_o
);
  logic [NUM_BOX-1:0]             wr_data, wr_set, wr_clr, rd_data;
  logic                           lock_rd, lock_wr, lock_free;
  logic [NUM_BOX-1:0][DATA_W-1:0] box_word;

  ipc_mbox_decode #(.ADDR_W(ADDR_W), .NUM_BOX(NUM_BOX)) dec_i (
    .addr    (bus_addr),
    .wen     (bus_wen),
    .ren     (bus_ren),
    .wr_data (wr_data),
    .wr_set  (wr_set),
    .wr_clr  (wr_clr),
    .rd_data (rd_data),
    .lock_rd (lock_rd),
    .lock_wr (lock_wr)
  );

  for (genvar i = 0; i < NUM_BOX; i++) begin : g_word
    ipc_mbox_word #(.DATA_W(DATA_W)) word_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_data (wr_data[i]),
      .wr_set  (wr_set[i]),
      .wr_clr  (wr_clr[i]),
      .wdata   (bus_wdata),
      .word_o  (box_word[i]),
      .irq_o   (irq_o[i])
    );
  end

  ipc_mbox_lock lock_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .acq_rd (lock_rd),
    .rel_wr (lock_wr & bus_wdata[0]),
    .free_o (lock_free)
  );

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_BOX; i++) begin
      if (rd_data[i]) bus_rdata = box_word[i];
    end
    if (lock_rd) bus_rdata = {{(DATA_W-1){1'b0}}, lock_free};
  end
endmodule

// File: rtl/ipc_mbox_chk.sv
module ipc_mbox_chk
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_BOX = 2
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [ADDR_W-1:0]              bus_addr,
  input logic                           bus_wen,
  input logic [DATA_W-1:0]              bus_wdata,
  input logic                           bus_ren,
  input logic [DATA_W-1:0]              bus_rdata,
  input logic [NUM_BOX-1:0]             irq_o,
  input logic [NUM_BOX-1:0][DATA_W-1:0] box_word,
  input logic                           lock_free
);
  localparam logic [ADDR_W-1:0] A_DAT0 = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(LOCK_OFS);

  logic lk_rd, lk_wr;
  assign lk_rd = bus_ren && (bus_addr == A_LOCK);
  assign lk_wr = bus_wen && (bus_addr == A_LOCK);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (box_word == '0) && (irq_o == '0) && lock_free); // R1
  AST_DATA_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && bus_addr == A_DAT0) |=> box_word[0] == $past(bus_wdata)); // R2
  AST_SET_OR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && bus_addr == A_SET0) |=> box_word[0] == ($past(box_word[0]) | $past(bus_wdata))); // R3
  AST_CLR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && bus_addr == A_CLR0) |=> box_word[0] == ($past(box_word[0]) & ~$past(bus_wdata))); // R4
  for (genvar g = 0; g < NUM_BOX; g++) begin : g_irq
    AST_IRQ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[g] == (|box_word[g])); // R5
  end
  AST_LOCK_GRANT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_rd && lock_free) |-> bus_rdata == DATA_W'(1)); // R6
  AST_LOCK_GRANT_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_rd && !(lk_wr && bus_wdata[0])) |=> !lock_free); // R6
  AST_LOCK_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_rd && !lock_free) |-> bus_rdata == '0); // R7
  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_wr && bus_wdata[0]) |=> lock_free); // R8
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_rd && !(lk_wr && bus_wdata[0])) |=> lock_free == $past(lock_free)); // R9
  AST_ALIAS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ren && (bus_addr == A_SET0 || bus_addr == A_CLR0)) |-> bus_rdata == '0); // R10
endmodule

bind ipc_mbox_top ipc_mbox_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BOX(NUM_BOX)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wen   (bus_wen),
  .bus_wdata (bus_wdata),
  .bus_ren   (bus_ren),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .box_word  (box_word),
  .lock_free (lock_free)
);

// File: tb/ipc_mbox_top_tb_top.sv
module ipc_mbox_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wen;
  logic [31:0] bus_wdata;
  logic        bus_ren;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_o;

  int n_vec  = 0;
  int n_fail = 0;

  logic [31:0] m_word [2];
  logic        m_free;

  ipc_mbox_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .bus_ren   (bus_ren),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Model of a read: returns the expected data and applies the lock side effect.
  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [31:0] r;
    r = '0;
    if (a[1:0] == 2'b00 && a[7:4] < 4'd2 && a[3:2] == 2'd0) r = m_word[a[4]];
    if (a == 8'hF8) begin
      r = {31'b0, m_free};
      m_free = 1'b0;
    end
    return r;
  endfunction

  function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
    if (a[1:0] == 2'b00 && a[7:4] < 4'd2) begin
      case (a[3:2])
        2'd0: m_word[a[4]] = d;
        2'd1: m_word[a[4]] = m_word[a[4]] | d;
        2'd2: m_word[a[4]] = m_word[a[4]] & ~d;
        default: ;
      endcase
    end
    if (a == 8'hF8 && d[0]) m_free = 1'b1;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a == 8'hF8) return m_free ? "R6" : "R7";
    if (a[1:0] == 2'b00 && a[7:4] < 4'd2 && a[3:2] == 2'd0) return "R2";
    return "R10";
  endfunction

  task automatic op(input logic wr, input logic [7:0] a, input logic [31:0] d, input string tag);
    logic [31:0] exp;
    string       t;
    @(negedge clk);
    bus_addr  = a;
    bus_wen   = wr;
    bus_ren   = !wr;
    bus_wdata = d;
    #1;
    if (!wr) begin
      t   = (tag == "") ? tag_of(a) : tag;
      exp = model_read(a);
      chk(t, bus_rdata, exp);
    end
    @(posedge clk);
    #1;
    bus_wen = 1'b0;
    bus_ren = 1'b0;
    if (wr) model_write(a, d);
    chk("R5 irq", {30'b0, irq_o}, {30'b0, |m_word[1], |m_word[0]});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wen = 1'b0; bus_ren = 1'b0; bus_wdata = '0;
    m_word[0] = '0; m_word[1] = '0; m_free = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq", {30'b0, irq_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    op(1'b0, 8'h00, '0, "R1 word0");
    op(1'b0, 8'h10, '0, "R1 word1");
    op(1'b0, 8'hF8, '0, "R1 lock free");
    // R7: second read denied
    op(1'b0, 8'hF8, '0, "R7 deny");
    // R9: foreign reads and writes leave lock taken
    op(1'b0, 8'h04, '0, "R10 alias");
    op(1'b1, 8'hF4, 32'hFFFF_FFFF, "");
    op(1'b1, 8'hF9, 32'h1, "");
    op(1'b0, 8'hF8, '0, "R9 still taken");
    // R8: write 0 keeps it, write 1 frees it
    op(1'b1, 8'hF8, 32'hFFFF_FFFE, "");
    op(1'b0, 8'hF8, '0, "R8 zero write");
    op(1'b1, 8'hF8, 32'h1, "");
    op(1'b0, 8'h10, '0, "R9 word1");
    op(1'b0, 8'hF8, '0, "R8 released");
    op(1'b1, 8'hF8, 32'h1, "");
    // R3: set alias
    op(1'b1, 8'h00, 32'h0000_00F0, "");
    op(1'b1, 8'h04, 32'h0000_000F, "");
    op(1'b0, 8'h00, '0, "R3 or");
    op(1'b1, 8'h04, 32'h0, "");
    op(1'b0, 8'h00, '0, "R3 zero");
    op(1'b1, 8'h14, 32'h8000_0000, "");
    op(1'b0, 8'h10, '0, "R3 box1");
    // R4: clear alias
    op(1'b1, 8'h08, 32'h0000_000F, "");
    op(1'b0, 8'h00, '0, "R4 clear");
    op(1'b1, 8'h08, 32'h0, "");
    op(1'b0, 8'h00, '0, "R4 zero");
    op(1'b1, 8'h08, 32'hFFFF_FFFF, "");
    op(1'b0, 8'h00, '0, "R4 all");
    op(1'b1, 8'h18, 32'hFFFF_FFFF, "");
    op(1'b0, 8'h10, '0, "R4 box1");
    // R10: misaligned accesses ignored
    op(1'b1, 8'h01, 32'h1234_5678, "");
    op(1'b0, 8'h00, '0, "R10 misaligned");

    // Sweep every word address with a write, then read both words and the target.
    for (int k = 0; k < 64; k++) begin
      logic [7:0]  a;
      logic [31:0] p;
      a = 8'(k * 4);
      p = (32'h1 << (k % 32)) ^ {8'(k), 8'(~k), 8'(k * 3), 8'(k)};
      op(1'b1, a, p, "");
      op(1'b0, 8'h00, '0, "");
      op(1'b0, 8'h10, '0, "");
      op(1'b0, a, '0, "");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule